// File: doc/BRIEF.md
# Register Rename Unit with Commit-Time Map

This block renames architectural registers to physical registers for an out-of-order core with 32 architectural and 40 physical registers. It holds three pieces of state:

- a speculative map, which the rename stage reads and writes;
- an architectural map, which only retiring instructions change;
- a circular FIFO of free physical tags.

Each cycle the rename port can accept one instruction. The instruction has two source register indices and an optional destination. For it the port returns the physical tags of both sources, a freshly allocated tag for the destination, and the tag that the destination was mapped to before. That previous tag travels with the instruction through the pipeline. When the instruction retires, the commit port writes the instruction's tag into the architectural map and returns the previous tag to the free FIFO.

On a misprediction, a flush pulse copies the architectural map over the speculative map. In the same cycle it refills the free FIFO with every tag that the architectural map does not reference, in ascending order. Scheduling, execution and the reorder buffer live elsewhere.

Top module: `rn_rename_unit`

## Requirements
- R1: After reset, every architectural index n (5-bit, 0..31) reads physical tag n (6-bit binary) on either source port.
- R2: After reset, the free FIFO holds exactly tags 32..39. Successive allocations return them in ascending order, starting with 32.
- R3: An accepted rename with a destination presents the FIFO head tag on `ren_pdst`. From the next cycle, reads of that destination index return this tag.
- R4: Source tags are read from the speculative map before the same instruction's destination write. A source equal to the destination sees the old tag.
- R5: `ren_pold` gives the tag that the destination index mapped to before the rename.
- R6: A rename with `ren_has_dst` low neither allocates a tag nor changes the speculative map.
- R7: `ren_ready` is low when the FIFO is empty and `ren_has_dst` is high. It is high when `ren_has_dst` is low, whatever the FIFO holds. `ren_ready` is also low during a flush cycle.
- R8: A commit with a destination appends `cmt_pold` at the FIFO tail. A tag freed in a cycle cannot be allocated in that same cycle.
- R9: The architectural map changes only on commit (index `cmt_dst` takes `cmt_pdst`). A flush makes the speculative map equal to the architectural map in one cycle. Commits asserted during a flush cycle are ignored.
- R10: After a flush, the FIFO holds every tag that the architectural map does not reference, in ascending order.
- R11: A rename presented while `ren_ready` is low changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request valid |
| ren_ready | output | 1 | Rename can be accepted this cycle |
| ren_src1 | input | 5 | First source architectural index |
| ren_src2 | input | 5 | Second source architectural index |
| ren_has_dst | input | 1 | Instruction writes a destination |
| ren_dst | input | 5 | Destination architectural index |
| ren_psrc1 | output | 6 | Physical tag of first source |
| ren_psrc2 | output | 6 | Physical tag of second source |
| ren_pdst | output | 6 | Newly allocated destination tag |
| ren_pold | output | 6 | Previous tag of the destination |
| cmt_valid | input | 1 | Commit valid |
| cmt_has_dst | input | 1 | Committing instruction has a destination |
| cmt_dst | input | 5 | Committing destination index |
| cmt_pdst | input | 6 | Tag the committing instruction wrote |
| cmt_pold | input | 6 | Stale tag to release |
| flush | input | 1 | Restore speculative state from the architectural map |

## Verification
A corrupted speculative map entry appears on a source tag in the very next cycle that reads that index. A FIFO pointer or count error appears as a wrong `ren_pdst` on the next allocation, or as `ren_ready` dropping early or late. A wrong architectural map stays hidden until a flush, so the bench flushes and then reads both restored mappings and the rebuilt allocation order. A lost or doubled release shows up as a displaced tag once the FIFO wraps.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // Advance a circular pointer through 0..depth-1.
  function automatic int wrap_inc(int p, int depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of pushes and pops.
  function automatic int next_count(int cnt, bit push, bit pop);
    return cnt + (push ? 1 : 0) - (pop ? 1 : 0);
  endfunction
endpackage

// File: rtl/rn_spec_map.sv
module rn_spec_map #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 40,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          rd_a,
  input  logic [AW-1:0]          rd_b,
  input  logic [AW-1:0]          rd_c,
  output logic [TW-1:0]          tag_a,
  output logic [TW-1:0]          tag_b,
  output logic [TW-1:0]          tag_c,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_idx,
  input  logic [TW-1:0]          wr_tag,
  input  logic                   restore,
  input  logic [NUM_ARCH*TW-1:0] restore_img,
  output logic [NUM_ARCH*TW-1:0] img
);
  logic [TW-1:0] map_q [NUM_ARCH];

  // Reads see the map as it stands before this cycle's write.
  assign tag_a = map_q[rd_a];
  assign tag_b = map_q[rd_b];
  assign tag_c = map_q[rd_c];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= TW'(i);
    end else if (restore) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= restore_img[i*TW +: TW];
    end else if (wr_en) begin
      map_q[wr_idx] <= wr_tag;
    end
  end

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_img
    assign img[g*TW +: TW] = map_q[g];
  end
endmodule

// File: rtl/rn_arch_map.sv
module rn_arch_map #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 40,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_idx,
  input  logic [TW-1:0]          wr_tag,
  output logic [NUM_ARCH*TW-1:0] img
);
  logic [TW-1:0] map_q [NUM_ARCH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= TW'(i);
    end else if (wr_en) begin
      map_q[wr_idx] <= wr_tag;
    end
  end

  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_img
    assign img[g*TW +: TW] = map_q[g];
  end
endmodule

// File: rtl/rn_free_fifo.sv
module rn_free_fifo
  import rn_pkg::*;
#(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 40,
  localparam int TW    = $clog2(NUM_PHYS),
  localparam int PW    = $clog2(NUM_PHYS),
  localparam int CW    = $clog2(NUM_PHYS + 1),
  localparam int SPARE = NUM_PHYS - NUM_ARCH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   pop,
  input  logic                   push,
  input  logic [TW-1:0]          push_tag,
  input  logic                   rebuild,
  input  logic [NUM_ARCH*TW-1:0] arch_img,
  output logic [TW-1:0]          head_tag,
  output logic [CW-1:0]          count
);
  logic [TW-1:0] mem_q [NUM_PHYS];
  logic [PW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  // Rebuild image: every tag not referenced by the architectural map, ascending.
  logic [NUM_PHYS-1:0] used;
  logic [TW-1:0]       rb_mem [NUM_PHYS];
  logic [CW-1:0]       rb_cnt;

  always_comb begin
    int n;
    used = '0;
    for (int k = 0; k < NUM_PHYS; k++) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        if (arch_img[a*TW +: TW] == TW'(k)) used[k] = 1'b1;
      end
    end
    n = 0;
    for (int k = 0; k < NUM_PHYS; k++) rb_mem[k] = '0;
    for (int k = 0; k < NUM_PHYS; k++) begin
      if (!used[k]) begin
        rb_mem[n] = TW'(k);
        n = n + 1;
      end
    end
    rb_cnt = CW'(n);
  end

  assign head_tag = mem_q[head_q];
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PHYS; i++)
        mem_q[i] <= (i < SPARE) ? TW'(NUM_ARCH + i) : '0;
      head_q <= '0;
      tail_q <= PW'(SPARE % NUM_PHYS);
      cnt_q  <= CW'(SPARE);
    end else if (rebuild) begin
      for (int i = 0; i < NUM_PHYS; i++) mem_q[i] <= rb_mem[i];
      head_q <= '0;
      tail_q <= PW'(int'(rb_cnt) % NUM_PHYS);
      cnt_q  <= rb_cnt;
    end else begin
      if (push) begin
        mem_q[tail_q] <= push_tag;
        tail_q <= PW'(wrap_inc(int'(tail_q), NUM_PHYS));
      end
      if (pop) head_q <= PW'(wrap_inc(int'(head_q), NUM_PHYS));
      cnt_q <= CW'(next_count(int'(cnt_q), push, pop));
    end
  end
endmodule

// File: rtl/rn_rename_unit.sv
module rn_rename_unit #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 40,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  output logic          ren_ready,
  input  logic [AW-1:0] ren_src1,
  input  logic [AW-1:0] ren_src2,
  input  logic          ren_has_dst,
  input  logic [AW-1:0] ren_dst,
  output logic [TW-1:0] ren_psrc1,
  output logic [TW-1:0] ren_psrc2,
  output logic [TW-1:0] ren_pdst,
  output logic [TW-1:0] ren_pold,
  input  logic          cmt_valid,
  input  logic          cmt_has_dst,
  input  logic [AW-1:0] cmt_dst,
  input  logic [TW-1:0] cmt_pdst,
  input  logic [TW-1:0] cmt_pold,
  input  logic          flush
);
  // Named internal events, visible to the bound checker.
  logic                   alloc_fire;
  logic                   free_push;
  logic [CW-1:0]          fl_count;
  logic [NUM_ARCH*TW-1:0] arch_img;
  logic [NUM_ARCH*TW-1:0] spec_img;

  assign ren_ready  = !flush && (!ren_has_dst || fl_count != '0);
  assign alloc_fire = ren_valid && ren_ready && ren_has_dst;
  assign free_push  = cmt_valid && cmt_has_dst && !flush;

  rn_spec_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_spec (
    .clk(clk), .rst_n(rst_n),
    .rd_a(ren_src1), .rd_b(ren_src2), .rd_c(ren_dst),
    .tag_a(ren_psrc1), .tag_b(ren_psrc2), .tag_c(ren_pold),
    .wr_en(alloc_fire), .wr_idx(ren_dst), .wr_tag(ren_pdst),
    .restore(flush), .restore_img(arch_img), .img(spec_img)
  );

  rn_arch_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_arch (
    .clk(clk), .rst_n(rst_n),
    .wr_en(free_push), .wr_idx(cmt_dst), .wr_tag(cmt_pdst),
    .img(arch_img)
  );

  rn_free_fifo #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc_fire), .push(free_push), .push_tag(cmt_pold),
    .rebuild(flush), .arch_img(arch_img),
    .head_tag(ren_pdst), .count(fl_count)
  );
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 40,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int TW = $clog2(NUM_PHYS),
  localparam int CW = $clog2(NUM_PHYS + 1)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ren_valid,
  input logic                   ren_ready,
  input logic                   ren_has_dst,
  input logic [AW-1:0]          ren_dst,
  input logic [TW-1:0]          ren_pdst,
  input logic                   alloc_fire,
  input logic                   free_push,
  input logic                   flush,
  input logic [CW-1:0]          fl_count,
  input logic [NUM_ARCH*TW-1:0] spec_img,
  input logic [NUM_ARCH*TW-1:0] arch_img
);
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fl_count <= CW'(NUM_PHYS));

  p_alloc_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire && !free_push && !flush |=> fl_count == $past(fl_count) - 1'b1);

  p_release_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_push && !alloc_fire && !flush |=> fl_count == $past(fl_count) + 1'b1);

  p_map_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire && !flush |=> spec_img[$past(ren_dst)*TW +: TW] == $past(ren_pdst));

  p_stall_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ren_has_dst && fl_count == '0 |-> !ren_ready);

  p_no_dst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ren_valid && !ren_has_dst && !free_push && !flush |=> $stable(fl_count) && $stable(spec_img));

  p_flush_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> spec_img == $past(arch_img));

  p_flush_refill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> fl_count == CW'(NUM_PHYS - NUM_ARCH));
endmodule

bind rn_rename_unit rn_rename_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
  .ren_has_dst(ren_has_dst), .ren_dst(ren_dst), .ren_pdst(ren_pdst),
  .alloc_fire(alloc_fire), .free_push(free_push), .flush(flush),
  .fl_count(fl_count), .spec_img(spec_img), .arch_img(arch_img)
);

// File: tb/rn_rename_unit_test.sv
module rn_rename_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ren_valid = 1'b0, ren_has_dst = 1'b0;
  logic [4:0] ren_src1 = '0, ren_src2 = '0, ren_dst = '0;
  logic       ren_ready;
  logic [5:0] ren_psrc1, ren_psrc2, ren_pdst, ren_pold;
  logic       cmt_valid = 1'b0, cmt_has_dst = 1'b0;
  logic [4:0] cmt_dst = '0;
  logic [5:0] cmt_pdst = '0, cmt_pold = '0;
  logic       flush = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rn_rename_unit uut (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_src1(ren_src1), .ren_src2(ren_src2), .ren_has_dst(ren_has_dst),
    .ren_dst(ren_dst), .ren_psrc1(ren_psrc1), .ren_psrc2(ren_psrc2),
    .ren_pdst(ren_pdst), .ren_pold(ren_pold), .cmt_valid(cmt_valid),
    .cmt_has_dst(cmt_has_dst), .cmt_dst(cmt_dst), .cmt_pdst(cmt_pdst),
    .cmt_pold(cmt_pold), .flush(flush)
  );

  // Vector: src1, src2, has_dst, dst, exp psrc1, exp psrc2, exp pdst, exp pold
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {5'd2, 5'd3, 1'b1, 5'd1, 6'd2,  6'd3,  6'd32, 6'd1},  // div  r1,r2,r3
    {5'd4, 5'd5, 1'b0, 5'd0, 6'd4,  6'd5,  6'd0,  6'd0},  // store r4,r5 (R6)
    {5'd1, 5'd5, 1'b1, 5'd7, 6'd32, 6'd5,  6'd33, 6'd7},  // add  r7,r1,r5
    {5'd5, 5'd2, 1'b1, 5'd1, 6'd5,  6'd2,  6'd34, 6'd32}, // or   r1,r5,r2
    {5'd6, 5'd0, 1'b1, 5'd4, 6'd6,  6'd0,  6'd35, 6'd4},  // load r4,r6
    {5'd1, 5'd4, 1'b1, 5'd3, 6'd34, 6'd35, 6'd36, 6'd3},  // sub  r3,r1,r4
    {5'd2, 5'd6, 1'b1, 5'd2, 6'd2,  6'd6,  6'd37, 6'd2}   // add  r2,r2,r6 (R4)
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic peek(input int idx, input int exp, input string req);
    @(negedge clk);
    ren_valid = 1'b0; ren_has_dst = 1'b0; ren_src1 = 5'(idx);
    #1;
    chk(req, int'(ren_psrc1), exp);
  endtask

  task automatic rename(input int dst, input int exp_pd, input int exp_po, input string req);
    @(negedge clk);
    ren_valid = 1'b1; ren_has_dst = 1'b1; ren_dst = 5'(dst);
    #1;
    chk({req, " ready"}, int'(ren_ready), 1);
    chk({req, " pdst"}, int'(ren_pdst), exp_pd);
    chk({req, " pold"}, int'(ren_pold), exp_po);
    @(posedge clk);
    #0.5;
    ren_valid = 1'b0;
  endtask

  task automatic commit(input int dst, input int pd, input int po);
    @(negedge clk);
    cmt_valid = 1'b1; cmt_has_dst = 1'b1;
    cmt_dst = 5'(dst); cmt_pdst = 6'(pd); cmt_pold = 6'(po);
    @(posedge clk);
    #0.5;
    cmt_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: identity mapping after reset
    peek(0, 0, "R1");
    peek(17, 17, "R1");
    peek(31, 31, "R1");
    // R2: first free tag is 32
    @(negedge clk); ren_has_dst = 1'b1; #1;
    chk("R2 head", int'(ren_pdst), 32);
    chk("R2 ready", int'(ren_ready), 1);

    // Table walk: R3, R4, R5, R6
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      {ren_src1, ren_src2, ren_has_dst, ren_dst} = VEC[v][39:24];
      ren_valid = 1'b1;
      #1;
      chk("R3 psrc1", int'(ren_psrc1), int'(VEC[v][23:18]));
      chk("R4 psrc2", int'(ren_psrc2), int'(VEC[v][17:12]));
      if (VEC[v][24+5]) begin
        chk("R3 pdst", int'(ren_pdst), int'(VEC[v][11:6]));
        chk("R5 pold", int'(ren_pold), int'(VEC[v][5:0]));
      end
      @(posedge clk);
    end
    @(negedge clk) ren_valid = 1'b0;
    peek(2, 37, "R3");
    peek(1, 34, "R3");

    // Retire in order; the store has no destination
    commit(1, 32, 1);
    commit(7, 33, 7);
    commit(1, 34, 32);
    commit(4, 35, 4);
    commit(3, 36, 3);
    commit(2, 37, 2);

    // R2 remainder then released tags in FIFO order (R8)
    rename(9,  38, 9,  "R2");
    rename(10, 39, 10, "R2");
    rename(11, 1,  11, "R8");
    rename(12, 7,  12, "R8");
    rename(13, 32, 13, "R8");
    rename(14, 4,  14, "R8");
    rename(15, 3,  15, "R8");
    rename(16, 2,  16, "R8");

    // R7: empty list stalls only instructions with a destination
    @(negedge clk); ren_valid = 1'b1; ren_has_dst = 1'b1; ren_dst = 5'd20; #1;
    chk("R7 stall", int'(ren_ready), 0);
    @(negedge clk); ren_has_dst = 1'b0; #1;
    chk("R7 no-dst ready", int'(ren_ready), 1);
    @(negedge clk); ren_valid = 1'b0;
    peek(20, 20, "R11");

    // R8: release and stalled rename in the same cycle
    @(negedge clk);
    ren_valid = 1'b1; ren_has_dst = 1'b1; ren_dst = 5'd21;
    cmt_valid = 1'b1; cmt_has_dst = 1'b1; cmt_dst = 5'd9; cmt_pdst = 6'd38; cmt_pold = 6'd9;
    #1;
    chk("R8 same-cycle", int'(ren_ready), 0);
    @(posedge clk); #0.5;
    cmt_valid = 1'b0; ren_valid = 1'b0;
    @(negedge clk); ren_has_dst = 1'b1; #1;
    chk("R8 ready", int'(ren_ready), 1);
    chk("R8 freed", int'(ren_pdst), 9);
    peek(21, 21, "R11");

    // R9, R10: flush
    @(negedge clk); flush = 1'b1; ren_has_dst = 1'b1; #1;
    chk("R7 flush", int'(ren_ready), 0);
    @(posedge clk); #0.5; flush = 1'b0;
    peek(9, 38, "R9");
    peek(10, 10, "R9");
    peek(2, 37, "R9");
    peek(12, 12, "R9");
    peek(7, 33, "R9");
    rename(25, 1,  25, "R10");
    rename(26, 2,  26, "R10");
    rename(27, 3,  27, "R10");
    rename(28, 4,  28, "R10");
    rename(29, 7,  29, "R10");
    rename(30, 9,  30, "R10");
    rename(31, 32, 31, "R10");
    rename(0,  39, 0,  "R10");
    @(negedge clk); ren_has_dst = 1'b1; #1;
    chk("R10 empty", int'(ren_ready), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule